// File: doc/BRIEF.md
# Predicated Vector Register Writeback Unit

This block is the last stage of a four-channel (R, G, B, A) shader datapath for one lane. Each cycle it may take one instruction result. It works out which channels may be written, from the write masks, a predicate vector chosen by a replicate/invert selector, and the lane's flow-control activity. It then updates a temporary register file, one of three render-target output registers or the lane's four predicate bits, and a dedicated W output.

The colour channels (R, G, B) and the alpha channel each have their own predicate selector and invert control. The destination register index can be offset by a loop counter, with wraparound. A combinational read port exposes any register file entry. The active flag and the loop counter are inputs; decode, arithmetic and flow control live elsewhere.

Top module: `pred_wb_unit`

## Requirements
- R1: After reset, every register file entry, the three render-target registers, the W output and the four predicate bits read zero.
- R2: Channel c (0=R, 1=G, 2=B, 3=A) occupies bits [c*CH_W +: CH_W] of every vector. When an instruction is accepted, destination channel c is written on the next clock edge only if its write-mask bit is set and its gating predicate is true. `rgb_wmask` bit 0/1/2 gates R/G/B and `alpha_wmask` gates A.
- R3: Predicate-select code 1 gives each channel its own predicate bit. Codes 2, 3, 4 and 5 replicate predicate bit R, G, B and A across all channels. Code 0 and the unused codes 6 and 7 disable predication, so the predicate is true.
- R4: A set invert bit complements the selected predicate vector. When predication is disabled the invert bit has no effect.
- R5: The RGB path gates R, G and B with bits 0..2 of its own selected vector. The alpha path gates A with bit 3 of a vector chosen by its independent select and invert.
- R6: With `add_loop` set, the destination index is (`dst_idx` + `loop_cnt`) modulo RF_DEPTH. Otherwise it is `dst_idx`.
- R7: No register, output or predicate state changes when `wb_valid` is low, or when `lane_active` is low and `write_inactive` is low. A set `write_inactive` lets an inactive lane write.
- R8: On an output instruction (`is_output`=1), target code 0/1/2 writes render target A/B/C. The channels written are those whose output-mask bit and gating predicate are both true. Non-output instructions leave all outputs unchanged.
- R9: Target code 3 writes the predicate bits instead. A channel enabled by its predicated output mask sets its predicate bit to 1 when its result channel is nonzero and to 0 otherwise.
- R10: On an output instruction, `w_omask` ANDed with the alpha-path predicate writes the alpha result channel to the W output.
- R11: A predicate bit written by one instruction gates the immediately following instruction. The instruction that writes it is gated by the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_valid | input | 1 | Instruction result present this cycle |
| lane_active | input | 1 | Flow-control active flag of the lane |
| write_inactive | input | 1 | Write even when the lane is inactive |
| res_data | input | 4*CH_W | Result vector, R in the low channel |
| dst_idx | input | IDX_W | Destination temporary index |
| add_loop | input | 1 | Add the loop counter to the index |
| loop_cnt | input | IDX_W | Loop counter |
| rgb_wmask | input | 3 | Register write mask for R, G, B |
| alpha_wmask | input | 1 | Register write mask for A |
| rgb_psel | input | 3 | RGB predicate-select code |
| rgb_pinv | input | 1 | RGB predicate invert |
| a_psel | input | 3 | Alpha predicate-select code |
| a_pinv | input | 1 | Alpha predicate invert |
| is_output | input | 1 | Output-type instruction |
| out_sel | input | 2 | 0/1/2 render target A/B/C, 3 predicate bits |
| rgb_omask | input | 3 | Output mask for R, G, B |
| alpha_omask | input | 1 | Output mask for A |
| w_omask | input | 1 | W output mask |
| rd_idx | input | IDX_W | Register file read index |
| rd_data | output | 4*CH_W | Register file entry at rd_idx |
| rt_a | output | 4*CH_W | Render target A |
| rt_b | output | 4*CH_W | Render target B |
| rt_c | output | 4*CH_W | Render target C |
| w_out | output | CH_W | W output |
| pred | output | 4 | Predicate bits, bit 0 = R |

## Verification
The bench builds the unit with CH_W=8 and RF_DEPTH=8. Narrow channels let random results that are biased toward zero drive predicate bits both ways. The small register file makes the loop-counter offset wrap past the top index on many instructions. After every clock the whole register file is swept through the read port, so a write to a wrong or wrapped index shows up at once.

// File: rtl/pred_wb_unit.sv
module pred_wb_unit #(
  parameter int CH_W     = 32,
  parameter int RF_DEPTH = 16,
  localparam int IDX_W   = $clog2(RF_DEPTH),
  localparam int VEC_W   = 4 * CH_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_valid,
  input  logic             lane_active,
  input  logic             write_inactive,
  input  logic [VEC_W-1:0] res_data,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             add_loop,
  input  logic [IDX_W-1:0] loop_cnt,
  input  logic [2:0]       rgb_wmask,
  input  logic             alpha_wmask,
  input  logic [2:0]       rgb_psel,
  input  logic             rgb_pinv,
  input  logic [2:0]       a_psel,
  input  logic             a_pinv,
  input  logic             is_output,
  input  logic [1:0]       out_sel,
  input  logic [2:0]       rgb_omask,
  input  logic             alpha_omask,
  input  logic             w_omask,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VEC_W-1:0] rd_data,
  output logic [VEC_W-1:0] rt_a,
  output logic [VEC_W-1:0] rt_b,
  output logic [VEC_W-1:0] rt_c,
  output logic [CH_W-1:0]  w_out,
  output logic [3:0]       pred
);

  function automatic logic [3:0] pick(input logic [2:0] s, input logic inv, input logic [3:0] p);
    logic [3:0] v;
    logic       off;
    off = 1'b0;
    case (s)
      3'd1:    v = p;
      3'd2:    v = {4{p[0]}};
      3'd3:    v = {4{p[1]}};
      3'd4:    v = {4{p[2]}};
      3'd5:    v = {4{p[3]}};
      default: begin v = 4'hf; off = 1'b1; end
    endcase
    return off ? 4'hf : (inv ? ~v : v);
  endfunction

  logic [VEC_W-1:0] rf_q [RF_DEPTH];
  logic [VEC_W-1:0] rt_q [3];
  logic [CH_W-1:0]  w_q;
  logic [3:0]       pred_q;

  logic [3:0]       rgb_pv, a_pv;
  logic             go, a_ok;
  logic [IDX_W-1:0] wr_idx;
  logic [3:0]       reg_en, out_en;
  logic             w_en;

  assign go     = wb_valid & (write_inactive | lane_active);
  assign rgb_pv = pick(rgb_psel, rgb_pinv, pred_q);
  assign a_pv   = pick(a_psel, a_pinv, pred_q);
  assign a_ok   = a_pv[3];
  assign wr_idx = add_loop ? IDX_W'(dst_idx + loop_cnt) : dst_idx;
  assign reg_en = {alpha_wmask & a_ok, rgb_wmask & rgb_pv[2:0]} & {4{go}};
  assign out_en = {alpha_omask & a_ok, rgb_omask & rgb_pv[2:0]} & {4{go & is_output}};
  assign w_en   = go & is_output & w_omask & a_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RF_DEPTH; i++) rf_q[i] <= '0;
    end else begin
      for (int c = 0; c < 4; c++)
        if (reg_en[c]) rf_q[wr_idx][c*CH_W +: CH_W] <= res_data[c*CH_W +: CH_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 3; t++) rt_q[t] <= '0;
      w_q    <= '0;
      pred_q <= '0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (out_en[c]) begin
          if (out_sel == 2'd3) pred_q[c] <= |res_data[c*CH_W +: CH_W];
          else                 rt_q[out_sel][c*CH_W +: CH_W] <= res_data[c*CH_W +: CH_W];
        end
      end
      if (w_en) w_q <= res_data[3*CH_W +: CH_W];
    end
  end

  assign rd_data = rf_q[rd_idx];
  assign rt_a    = rt_q[0];
  assign rt_b    = rt_q[1];
  assign rt_c    = rt_q[2];
  assign w_out   = w_q;
  assign pred    = pred_q;

endmodule

module pred_wb_chk #(
  parameter int CH_W = 32,
  localparam int VEC_W = 4 * CH_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wb_valid,
  input logic             lane_active,
  input logic             write_inactive,
  input logic             is_output,
  input logic [1:0]       out_sel,
  input logic [2:0]       rgb_omask,
  input logic             alpha_omask,
  input logic [2:0]       rgb_psel,
  input logic [2:0]       a_psel,
  input logic [VEC_W-1:0] res_data,
  input logic [VEC_W-1:0] rt_a,
  input logic [VEC_W-1:0] rt_b,
  input logic [VEC_W-1:0] rt_c,
  input logic [CH_W-1:0]  w_out,
  input logic [3:0]       pred
);

  // R7
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_valid || (!lane_active && !write_inactive)) |=>
      $stable(pred) && $stable(rt_a) && $stable(rt_b) && $stable(rt_c) && $stable(w_out));

  // R8
  non_output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_output |=> $stable(rt_a) && $stable(rt_b) && $stable(rt_c) && $stable(w_out));

  // R9
  pred_unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_omask == 3'd0 && !alpha_omask) |=> $stable(pred));

  // R8
  full_target_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && lane_active && is_output && out_sel == 2'd0 && rgb_psel == 3'd0 &&
     a_psel == 3'd0 && rgb_omask == 3'd7 && alpha_omask) |=> rt_a == $past(res_data));

  // R3
  unused_code_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && lane_active && is_output && out_sel == 2'd1 && rgb_psel >= 3'd6 &&
     a_psel >= 3'd6 && rgb_omask == 3'd7 && alpha_omask) |=> rt_b == $past(res_data));

endmodule

bind pred_wb_unit pred_wb_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .lane_active(lane_active),
  .write_inactive(write_inactive), .is_output(is_output), .out_sel(out_sel),
  .rgb_omask(rgb_omask), .alpha_omask(alpha_omask), .rgb_psel(rgb_psel),
  .a_psel(a_psel), .res_data(res_data), .rt_a(rt_a), .rt_b(rt_b), .rt_c(rt_c),
  .w_out(w_out), .pred(pred));

// File: tb/tb_pred_wb_unit.sv
`timescale 1ns/1ps
module tb_pred_wb_unit;
  localparam int CW = 8;
  localparam int DEP = 8;
  localparam int IW = 3;
  localparam int VW = 4 * CW;

  logic clk = 0, rst_n = 0;
  logic wb_valid, lane_active, write_inactive, add_loop, alpha_wmask, rgb_pinv, a_pinv;
  logic is_output, alpha_omask, w_omask;
  logic [VW-1:0] res_data;
  logic [IW-1:0] dst_idx, loop_cnt, rd_idx;
  logic [2:0] rgb_wmask, rgb_psel, a_psel, rgb_omask;
  logic [1:0] out_sel;
  logic [VW-1:0] rd_data, rt_a, rt_b, rt_c;
  logic [CW-1:0] w_out;
  logic [3:0] pred;

  pred_wb_unit #(.CH_W(CW), .RF_DEPTH(DEP)) dut (.*);

  always #2 clk = ~clk;

  logic [VW-1:0] m_rf [DEP];
  logic [VW-1:0] m_rt [3];
  logic [CW-1:0] m_w;
  logic [3:0]    m_pred;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  function automatic logic [3:0] mpick(int s, bit inv, logic [3:0] p);
    logic [3:0] r;
    if (s == 0 || s > 5) return 4'hf;
    if (s == 1) r = p;
    else for (int k = 0; k < 4; k++) r[k] = p[s-2];
    return inv ? ~r : r;
  endfunction

  task automatic chk(string tag, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rt_a", rt_a, m_rt[0]);
    chk(tag, "rt_b", rt_b, m_rt[1]);
    chk(tag, "rt_c", rt_c, m_rt[2]);
    chk(tag, "w_out", VW'(w_out), VW'(m_w));
    chk(tag, "pred", VW'(pred), VW'(m_pred));
    for (int i = 0; i < DEP; i++) begin
      rd_idx = IW'(i);
      #0.1;
      chk(tag, $sformatf("rf[%0d]", i), rd_data, m_rf[i]);
    end
  endtask

  task automatic idle();
    wb_valid = 0; lane_active = 1; write_inactive = 0; add_loop = 0; loop_cnt = 0;
    dst_idx = 0; rgb_wmask = 0; alpha_wmask = 0; rgb_psel = 0; rgb_pinv = 0;
    a_psel = 0; a_pinv = 0; is_output = 0; out_sel = 0; rgb_omask = 0;
    alpha_omask = 0; w_omask = 0; res_data = 0; rd_idx = 0;
  endtask

  task automatic step(string tag);
    logic [3:0] rp, ap, re, oe;
    bit go;
    int idx;
    rp = mpick(rgb_psel, rgb_pinv, m_pred);
    ap = mpick(a_psel, a_pinv, m_pred);
    go = wb_valid && (write_inactive || lane_active);
    re = {alpha_wmask & ap[3], rgb_wmask & rp[2:0]};
    oe = {alpha_omask & ap[3], rgb_omask & rp[2:0]};
    idx = add_loop ? (dst_idx + loop_cnt) % DEP : dst_idx;
    if (go) begin
      for (int c = 0; c < 4; c++) begin
        if (re[c]) m_rf[idx][c*CW +: CW] = res_data[c*CW +: CW];
        if (is_output && oe[c]) begin
          if (out_sel == 3) m_pred[c] = (res_data[c*CW +: CW] != 0);
          else m_rt[out_sel][c*CW +: CW] = res_data[c*CW +: CW];
        end
      end
      if (is_output && w_omask && ap[3]) m_w = res_data[3*CW +: CW];
    end
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic set_pred(logic [3:0] p);
    idle(); wb_valid = 1; is_output = 1; out_sel = 3; rgb_omask = 7; alpha_omask = 1;
    for (int c = 0; c < 4; c++) res_data[c*CW +: CW] = p[c] ? CW'(c + 1) : '0;
    step("R9");
  endtask

  function automatic logic [CW-1:0] rch();
    return ($urandom % 2) ? CW'($urandom) : '0;
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEP; i++) m_rf[i] = 0;
    for (int t = 0; t < 3; t++) m_rt[t] = 0;
    m_w = 0; m_pred = 0;
    idle();
    #9 rst_n = 1;
    #1 compare("R1");

    // R2: plain and partial writes
    idle(); wb_valid = 1; dst_idx = 2; rgb_wmask = 7; alpha_wmask = 1; res_data = 32'h44332211;
    step("R2");
    idle(); wb_valid = 1; dst_idx = 2; rgb_wmask = 3'b010; res_data = 32'hAABBCCDD;
    step("R2");
    idle(); wb_valid = 1; dst_idx = 3; alpha_wmask = 1; res_data = 32'h5A000000;
    step("R2");

    // R9 then R3/R5 modes over pattern 0101 (R and B set)
    set_pred(4'b0101);
    set_pred(4'b1100);
    set_pred(4'b0101);
    for (int s = 0; s < 8; s++) begin
      idle(); wb_valid = 1; dst_idx = IW'(s); rgb_wmask = 7; alpha_wmask = 1;
      rgb_psel = 3'(s); a_psel = 3'(s); res_data = 32'h0F0E0D0C + s;
      step("R3");
    end
    // R5: independent alpha select
    idle(); wb_valid = 1; dst_idx = 4; rgb_wmask = 7; alpha_wmask = 1;
    rgb_psel = 3'd2; a_psel = 3'd3; res_data = 32'h99887766;
    step("R5");
    idle(); wb_valid = 1; dst_idx = 5; rgb_wmask = 7; alpha_wmask = 1;
    rgb_psel = 3'd3; a_psel = 3'd4; res_data = 32'h12345678;
    step("R5");
    // R4: invert and invert with NONE
    for (int s = 0; s < 8; s++) begin
      idle(); wb_valid = 1; dst_idx = IW'(s); rgb_wmask = 7; alpha_wmask = 1;
      rgb_psel = 3'(s); a_psel = 3'(7 - s); rgb_pinv = 1; a_pinv = 1; res_data = 32'hC0C1C2C3 ^ s;
      step("R4");
    end

    // R6: loop offset with wrap
    idle(); wb_valid = 1; dst_idx = 6; add_loop = 1; loop_cnt = 5; rgb_wmask = 7; alpha_wmask = 1;
    res_data = 32'hDEADBEEF; step("R6");
    idle(); wb_valid = 1; dst_idx = 6; add_loop = 0; loop_cnt = 1; rgb_wmask = 7; alpha_wmask = 1;
    res_data = 32'hFEEDFACE; step("R6");

    // R7: inactive lane, override, invalid
    idle(); wb_valid = 1; lane_active = 0; dst_idx = 1; rgb_wmask = 7; alpha_wmask = 1;
    is_output = 1; out_sel = 0; rgb_omask = 7; alpha_omask = 1; w_omask = 1; res_data = 32'h01010101;
    step("R7");
    write_inactive = 1; step("R7");
    idle(); dst_idx = 0; rgb_wmask = 7; alpha_wmask = 1; is_output = 1; out_sel = 3;
    rgb_omask = 7; alpha_omask = 1; res_data = 32'h0; step("R7");

    // R8 / R10: targets, non-output, W
    for (int t = 0; t < 3; t++) begin
      idle(); wb_valid = 1; is_output = 1; out_sel = 2'(t); rgb_omask = 3'(t + 3);
      alpha_omask = t[0]; w_omask = 1; res_data = 32'h70605040 + t;
      step("R8");
    end
    idle(); wb_valid = 1; rgb_omask = 7; alpha_omask = 1; w_omask = 1; res_data = 32'h11111111;
    step("R8");
    idle(); wb_valid = 1; is_output = 1; w_omask = 1; a_psel = 3'd1; res_data = 32'h77000000;
    step("R10");

    // R11: write predicate then use it back to back
    set_pred(4'b0000);
    idle(); wb_valid = 1; is_output = 1; out_sel = 3; rgb_omask = 7; alpha_omask = 1;
    rgb_psel = 3'd1; a_psel = 3'd1; res_data = 32'h01010101; step("R11");
    idle(); wb_valid = 1; dst_idx = 7; rgb_wmask = 7; alpha_wmask = 1; rgb_psel = 1; a_psel = 1;
    res_data = 32'h0BADCAFE; step("R11");

    // random mix over all requirements
    for (int n = 0; n < 600; n++) begin
      idle();
      wb_valid = ($urandom % 8) != 0; lane_active = ($urandom % 4) != 0;
      write_inactive = ($urandom % 4) == 0; add_loop = $urandom; loop_cnt = IW'($urandom);
      dst_idx = IW'($urandom); rgb_wmask = 3'($urandom); alpha_wmask = $urandom;
      rgb_psel = 3'($urandom); rgb_pinv = $urandom; a_psel = 3'($urandom); a_pinv = $urandom;
      is_output = $urandom; out_sel = 2'($urandom); rgb_omask = 3'($urandom);
      alpha_omask = $urandom; w_omask = $urandom;
      res_data = {rch(), rch(), rch(), rch()};
      step("RND");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule